// File: doc/BRIEF.md
# Crypto Accelerator Control and Status Register File

This block is the register file that sits between a 32-bit processor bus and a descriptor-driven crypto engine. Software writes the address of a descriptor chain to start a job. It watches a status word that packs a three-bit engine state with activity and mode flags, and it acknowledges completions and errors through a write-one command register. The engine reports back through single-cycle done, error and fault pulses. Alongside them it supplies an error code, a faulting address, the descriptor it is working on, an internal state byte and its active-unit flags. The cipher and hash datapaths are outside this block.

A second descriptor address written while a job runs is held in a one-deep slot. It is launched when the running job completes cleanly and dropped if the job ends in error or fault. A sticky pending flag, gated by an enable bit in the control register, drives the interrupt line. All results are registered on the clock edge that samples the bus write or engine pulse, except the status activity byte and unit flags, which are live.

Top module: `acc_csr_top`

## Requirements
- R1: After reset the status register (offset 0x10) reads 0x0002_0000 (state 0 = idle, dedicated-mode bit 17 set), the control register (offset 0x08) reads the `CTRL_RST` parameter value (default 0x0008_0000), and `irq` is low.
- R2: The version register (offset 0x00) reads the variant number in bits [7:0] when `VARIANT` is 3, and in bits [15:8] when `VARIANT` is 4 or more. All other bits read zero.
- R3: A write to the descriptor register (offset 0x04) while the state is idle (0) or complete (4) raises `job_start` for exactly the next cycle, with `job_addr` equal to the written value. In that same next cycle the state reads busy (1), and the initial-address register (0x20) and current-address register (0x1C) read the written value.
- R4: A descriptor write while busy sets status bit 3 (queue full), and offset 0x04 then reads the held address. A further write while the queue is full is dropped. A clean completion launches the held address as in R3, keeps the state busy and clears bit 3.
- R5: A done pulse while busy with nothing queued moves the state to complete (4) and sets the pending flag. A command write with bit 8 set clears pending and returns a complete state to idle.
- R6: An error pulse while busy moves the state to error (2), sets status bit 4, captures the 30-bit error code into offset 0x14 bits [29:0], and drops any queued address. Command bit 8 alone clears pending but leaves state 2. Command bit 9 clears bit 4, zeroes offset 0x14, and returns an error or fault state to idle.
- R7: A fault pulse while busy moves the state to fault (3), sets status bit 4 and pending, and captures the fault address into offset 0x18. Fault takes priority over error, and error over done, when they arrive together.
- R8: `irq` is high exactly when control bit 4 (interrupt enable) and the pending flag are both set. Pending is set by every completion, error or fault, including a completion that launches a queued address.
- R9: A command write with bit 0 set returns the state to idle, clears pending, error, queue-full and batch, and restores the control register to `CTRL_RST`.
- R10: A command write with bit 16 set selects batch mode: status bit 16 reads 1 and bit 17 reads 0 until the next soft reset. Otherwise bit 17 reads 1.
- R11: Only control bits [31:16], 7 and 4 are writable; all other control bits read zero.
- R12: Status bits 9, 10 and 11 follow `eng_units` bits 0, 1 and 2, and status bits [31:24] follow `eng_istate`, in the same cycle.
- R13: Engine pulses outside the busy state have no effect. A descriptor write in the error or fault state is ignored. While busy, offset 0x1C takes `eng_cur_addr` on every clock edge.
- R14: Offsets other than the nine registers, and any offset with bits [1:0] not zero, read zero and ignore writes. Writes to the read-only offsets 0x00, 0x10, 0x14, 0x18, 0x1C and 0x20 change nothing, and offset 0x0C reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| job_start | output | 1 | One-cycle pulse telling the engine to fetch a descriptor |
| job_addr | output | 32 | Descriptor address that goes with `job_start` |
| eng_done | input | 1 | Engine finished the job cleanly (pulse) |
| eng_err | input | 1 | Engine finished the job with an error (pulse) |
| eng_fault | input | 1 | Engine hit a hardware fault (pulse) |
| eng_err_info | input | 30 | Error code captured with `eng_err` |
| eng_fault_addr | input | 32 | Address captured with `eng_fault` |
| eng_cur_addr | input | 32 | Descriptor currently being processed |
| eng_units | input | 3 | Active flags: bit 0 random source, bit 1 hash, bit 2 cipher |
| eng_istate | input | 8 | Engine internal state byte |
| irq | output | 1 | Interrupt request |

## Verification
Every bus write and engine pulse takes effect on the clock edge that samples it. Register contents, `irq` and `job_start` therefore change one edge after the stimulus, and a queued launch also appears one edge after the done pulse that frees it. The status unit flags and state byte are combinational and show in the same cycle. The bench drives inputs a quarter period after the rising edge and compares outputs at the falling edge against a behavioural model that steps on the same rising edge. Directed reads move the address only after a rising edge, so the model and the design read the same offset.

// File: rtl/acc_csr_pkg.sv
package acc_csr_pkg;

  localparam int DW      = 32;
  localparam int NREG    = 9;
  localparam int EINFO_W = 30;
  localparam int UNITS_W = 3;

  // register slots, word index = byte offset / 4
  localparam int IX_VER   = 0;
  localparam int IX_DESC  = 1;
  localparam int IX_CTRL  = 2;
  localparam int IX_CMD   = 3;
  localparam int IX_STAT  = 4;
  localparam int IX_ESTAT = 5;
  localparam int IX_FADDR = 6;
  localparam int IX_CUR   = 7;
  localparam int IX_INIT  = 8;

  // command bits (write-one)
  localparam int CMD_RST   = 0;
  localparam int CMD_CLRI  = 8;
  localparam int CMD_CLRE  = 9;
  localparam int CMD_BATCH = 16;

  localparam logic [DW-1:0] CTRL_MASK = 32'hFFFF_0090;
  localparam int CTRL_IE = 4;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BUSY  = 3'd1,
    ST_ERR   = 3'd2,
    ST_FAULT = 3'd3,
    ST_DONE  = 3'd4
  } eng_st_t;

  function automatic logic [DW-1:0] ver_word(input int variant);
    logic [7:0] v;
    v = 8'(variant);
    if (variant >= 4) return {16'h0, v, 8'h0};
    return {24'h0, v};
  endfunction

  function automatic logic [DW-1:0] stat_word(input eng_st_t st, input logic full,
                                              input logic errf,
                                              input logic [UNITS_W-1:0] units,
                                              input logic batch,
                                              input logic [7:0] istate);
    logic [DW-1:0] s;
    s        = '0;
    s[2:0]   = st;
    s[3]     = full;
    s[4]     = errf;
    s[11:9]  = units;
    s[16]    = batch;
    s[17]    = ~batch;
    s[31:24] = istate;
    return s;
  endfunction

  function automatic logic st_may_launch(input eng_st_t st);
    return (st == ST_IDLE) || (st == ST_DONE);
  endfunction

  function automatic logic st_is_error(input eng_st_t st);
    return (st == ST_ERR) || (st == ST_FAULT);
  endfunction

endpackage

// File: rtl/acc_csr_bus.sv
module acc_csr_bus
  import acc_csr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NREG-1:0][DW-1:0]  rd_vals,
  output logic [NREG-1:0]          wr_sel,
  output logic [DW-1:0]            rdata
);
  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] idx;
  logic          aligned;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wr_sel[g] = bus_wr & aligned & (idx == IW'(g));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (aligned && (idx == IW'(i))) rdata = rd_vals[i];
    end
  end

endmodule

// File: rtl/acc_csr_job.sv
module acc_csr_job
  import acc_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_desc,
  input  logic          wr_cmd,
  input  logic [DW-1:0] wdata,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic          eng_fault,
  input  logic [DW-1:0] eng_cur_addr,
  output eng_st_t       st_q,
  output logic          full_q,
  output logic [DW-1:0] held_q,
  output logic [DW-1:0] init_q,
  output logic [DW-1:0] cur_q,
  output logic          pend_q,
  output logic          errf_q,
  output logic          start_q,
  output logic [DW-1:0] start_addr_q,
  output logic          ev_soft_rst,
  output logic          ev_clr_err,
  output logic          ev_launch,
  output logic          ev_queue,
  output logic          ev_err_take,
  output logic          ev_fault_take,
  output logic          ev_relaunch
);
  logic          busy;
  logic          ev_clr_int;
  logic          ev_done_take;
  logic [DW-1:0] relaunch_addr;

  assign busy          = (st_q == ST_BUSY);
  assign ev_soft_rst   = wr_cmd & wdata[CMD_RST];
  assign ev_clr_int    = wr_cmd & wdata[CMD_CLRI] & ~ev_soft_rst;
  assign ev_clr_err    = wr_cmd & wdata[CMD_CLRE] & ~ev_soft_rst;
  assign ev_launch     = wr_desc & st_may_launch(st_q);
  assign ev_queue      = wr_desc & busy & ~full_q;
  assign ev_fault_take = busy & eng_fault;
  assign ev_err_take   = busy & eng_err & ~eng_fault;
  assign ev_done_take  = busy & eng_done & ~eng_err & ~eng_fault;
  assign ev_relaunch   = ev_done_take & (full_q | ev_queue);
  assign relaunch_addr = full_q ? held_q : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      full_q       <= 1'b0;
      held_q       <= '0;
      init_q       <= '0;
      cur_q        <= '0;
      pend_q       <= 1'b0;
      errf_q       <= 1'b0;
      start_q      <= 1'b0;
      start_addr_q <= '0;
    end else if (ev_soft_rst) begin
      st_q    <= ST_IDLE;
      full_q  <= 1'b0;
      pend_q  <= 1'b0;
      errf_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= ev_launch | ev_relaunch;
      if (ev_clr_int) begin
        pend_q <= 1'b0;
        if (st_q == ST_DONE) st_q <= ST_IDLE;
      end
      if (ev_clr_err) begin
        errf_q <= 1'b0;
        if (st_is_error(st_q)) st_q <= ST_IDLE;
      end
      if (ev_launch) begin
        st_q         <= ST_BUSY;
        init_q       <= wdata;
        cur_q        <= wdata;
        start_addr_q <= wdata;
      end
      if (busy) cur_q <= eng_cur_addr;
      if (ev_queue) begin
        full_q <= 1'b1;
        held_q <= wdata;
      end
      if (ev_fault_take) begin
        st_q   <= ST_FAULT;
        errf_q <= 1'b1;
        pend_q <= 1'b1;
        full_q <= 1'b0;
      end else if (ev_err_take) begin
        st_q   <= ST_ERR;
        errf_q <= 1'b1;
        pend_q <= 1'b1;
        full_q <= 1'b0;
      end else if (ev_done_take) begin
        pend_q <= 1'b1;
        full_q <= 1'b0;
        if (ev_relaunch) begin
          init_q       <= relaunch_addr;
          cur_q        <= relaunch_addr;
          start_addr_q <= relaunch_addr;
        end else begin
          st_q <= ST_DONE;
        end
      end
    end
  end

endmodule

// File: rtl/acc_csr_cfg.sv
module acc_csr_cfg
  import acc_csr_pkg::*;
#(
  parameter logic [31:0] CTRL_RST = 32'h0008_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_cmd,
  input  logic          ev_soft_rst,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic          batch_q
);
  localparam logic [DW-1:0] CTRL_INIT = CTRL_RST & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_INIT;
      batch_q <= 1'b0;
    end else if (ev_soft_rst) begin
      ctrl_q  <= CTRL_INIT;
      batch_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
      if (wr_cmd && wdata[CMD_BATCH]) batch_q <= 1'b1;
    end
  end

endmodule

// File: rtl/acc_csr_errcap.sv
module acc_csr_errcap
  import acc_csr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_soft_rst,
  input  logic               ev_clr_err,
  input  logic               ev_err_take,
  input  logic               ev_fault_take,
  input  logic [EINFO_W-1:0] eng_err_info,
  input  logic [DW-1:0]      eng_fault_addr,
  output logic [EINFO_W-1:0] estat_q,
  output logic [DW-1:0]      faddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      estat_q <= '0;
      faddr_q <= '0;
    end else if (ev_soft_rst) begin
      estat_q <= '0;
      faddr_q <= '0;
    end else begin
      if (ev_err_take)     estat_q <= eng_err_info;
      else if (ev_clr_err) estat_q <= '0;
      if (ev_fault_take)   faddr_q <= eng_fault_addr;
    end
  end

endmodule

// File: rtl/acc_csr_top.sv
module acc_csr_top
  import acc_csr_pkg::*;
#(
  parameter int          VARIANT  = 3,
  parameter int          ADDR_W   = 6,
  parameter logic [31:0] CTRL_RST = 32'h0008_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                job_start,
  output logic [31:0]         job_addr,
  input  logic                eng_done,
  input  logic                eng_err,
  input  logic                eng_fault,
  input  logic [29:0]         eng_err_info,
  input  logic [31:0]         eng_fault_addr,
  input  logic [31:0]         eng_cur_addr,
  input  logic [2:0]          eng_units,
  input  logic [7:0]          eng_istate,
  output logic                irq
);
  localparam logic [DW-1:0] VER_VAL = ver_word(VARIANT);

  logic [NREG-1:0]         wr_sel;
  logic [NREG-1:0][DW-1:0] rd_vals;

  eng_st_t             st_q;
  logic                full_q, pend_q, errf_q, batch_q;
  logic [DW-1:0]       held_q, init_q, cur_q, ctrl_q, faddr_q;
  logic [EINFO_W-1:0]  estat_q;
  logic                ev_soft_rst, ev_clr_err, ev_launch, ev_queue;
  logic                ev_err_take, ev_fault_take, ev_relaunch;
  logic                ctrl_ie;

  acc_csr_bus #(.ADDR_W(ADDR_W)) u_bus (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .rd_vals  (rd_vals),
    .wr_sel   (wr_sel),
    .rdata    (bus_rdata)
  );

  acc_csr_job u_job (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_desc       (wr_sel[IX_DESC]),
    .wr_cmd        (wr_sel[IX_CMD]),
    .wdata         (bus_wdata),
    .eng_done      (eng_done),
    .eng_err       (eng_err),
    .eng_fault     (eng_fault),
    .eng_cur_addr  (eng_cur_addr),
    .st_q          (st_q),
    .full_q        (full_q),
    .held_q        (held_q),
    .init_q        (init_q),
    .cur_q         (cur_q),
    .pend_q        (pend_q),
    .errf_q        (errf_q),
    .start_q       (job_start),
    .start_addr_q  (job_addr),
    .ev_soft_rst   (ev_soft_rst),
    .ev_clr_err    (ev_clr_err),
    .ev_launch     (ev_launch),
    .ev_queue      (ev_queue),
    .ev_err_take   (ev_err_take),
    .ev_fault_take (ev_fault_take),
    .ev_relaunch   (ev_relaunch)
  );

  acc_csr_cfg #(.CTRL_RST(CTRL_RST)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_sel[IX_CTRL]),
    .wr_cmd      (wr_sel[IX_CMD]),
    .ev_soft_rst (ev_soft_rst),
    .wdata       (bus_wdata),
    .ctrl_q      (ctrl_q),
    .batch_q     (batch_q)
  );

  acc_csr_errcap u_err (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_soft_rst    (ev_soft_rst),
    .ev_clr_err     (ev_clr_err),
    .ev_err_take    (ev_err_take),
    .ev_fault_take  (ev_fault_take),
    .eng_err_info   (eng_err_info),
    .eng_fault_addr (eng_fault_addr),
    .estat_q        (estat_q),
    .faddr_q        (faddr_q)
  );

  always_comb begin
    rd_vals           = '0;
    rd_vals[IX_VER]   = VER_VAL;
    rd_vals[IX_DESC]  = full_q ? held_q : '0;
    rd_vals[IX_CTRL]  = ctrl_q;
    rd_vals[IX_CMD]   = '0;
    rd_vals[IX_STAT]  = stat_word(st_q, full_q, errf_q, eng_units, batch_q, eng_istate);
    rd_vals[IX_ESTAT] = {{(DW-EINFO_W){1'b0}}, estat_q};
    rd_vals[IX_FADDR] = faddr_q;
    rd_vals[IX_CUR]   = cur_q;
    rd_vals[IX_INIT]  = init_q;
  end

  assign ctrl_ie = ctrl_q[CTRL_IE];
  assign irq     = ctrl_ie & pend_q;

endmodule

// File: rtl/acc_csr_chk.sv
module acc_csr_chk
  import acc_csr_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input eng_st_t       st_q,
  input logic          full_q,
  input logic          pend_q,
  input logic          errf_q,
  input logic          irq,
  input logic          ctrl_ie,
  input logic          job_start,
  input logic          ev_launch,
  input logic          ev_soft_rst,
  input logic          ev_clr_err,
  input logic          ev_err_take,
  input logic          ev_fault_take,
  input logic          ev_relaunch,
  input logic          eng_done,
  input logic          eng_err,
  input logic          eng_fault,
  input logic          bus_wr
);
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (job_start && st_q == ST_BUSY));

  p_full_only_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (st_q == ST_BUSY));

  p_relaunch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_relaunch |=> (job_start && st_q == ST_BUSY && !full_q && pend_q));

  p_done_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> pend_q);

  p_errflag_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    errf_q |-> st_is_error(st_q));

  p_err_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_take |=> (st_q == ST_ERR && errf_q && !full_q));

  p_clr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr_err && st_is_error(st_q)) |=> (st_q == ST_IDLE && !errf_q));

  p_fault_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault_take |=> (st_q == ST_FAULT && pend_q));

  p_irq_needs_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl_ie && pend_q));

  p_soft_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> (st_q == ST_IDLE && !pend_q && !full_q && !errf_q && !irq));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_BUSY && !bus_wr && (eng_done || eng_err || eng_fault)) |=> $stable(st_q));

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q <= ST_DONE));

endmodule

bind acc_csr_top acc_csr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .st_q          (st_q),
  .full_q        (full_q),
  .pend_q        (pend_q),
  .errf_q        (errf_q),
  .irq           (irq),
  .ctrl_ie       (ctrl_ie),
  .job_start     (job_start),
  .ev_launch     (ev_launch),
  .ev_soft_rst   (ev_soft_rst),
  .ev_clr_err    (ev_clr_err),
  .ev_err_take   (ev_err_take),
  .ev_fault_take (ev_fault_take),
  .ev_relaunch   (ev_relaunch),
  .eng_done      (eng_done),
  .eng_err       (eng_err),
  .eng_fault     (eng_fault),
  .bus_wr        (bus_wr)
);

// File: tb/tb_acc_csr_top.sv
`timescale 1ns/1ps
module tb_acc_csr_top;
  localparam int          PERIOD  = 10;
  localparam int          VAR     = 3;
  localparam logic [31:0] CRST    = 32'h0008_0000;
  localparam logic [31:0] CWMASK  = 32'hFFFF_0090;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_wr = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic        e_done = 1'b0, e_err = 1'b0, e_fault = 1'b0;
  logic [29:0] e_info = '0;
  logic [31:0] e_faddr = '0, e_cur = '0;
  logic [2:0]  e_units = '0;
  logic [7:0]  e_istate = '0;
  logic [31:0] rdata, jaddr;
  logic        jstart, irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  acc_csr_top #(.VARIANT(VAR), .ADDR_W(6), .CTRL_RST(CRST)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(rdata), .job_start(jstart), .job_addr(jaddr),
    .eng_done(e_done), .eng_err(e_err), .eng_fault(e_fault), .eng_err_info(e_info),
    .eng_fault_addr(e_faddr), .eng_cur_addr(e_cur), .eng_units(e_units),
    .eng_istate(e_istate), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_st;
  bit          m_full, m_pend, m_errf, m_batch, m_start;
  logic [31:0] m_held, m_init, m_cur, m_ctrl, m_fa, m_jaddr, m_es;
  bit          m_live = 1'b0;

  task automatic model_reset();
    m_st = 0; m_full = 0; m_pend = 0; m_errf = 0; m_batch = 0; m_start = 0;
    m_held = 0; m_init = 0; m_cur = 0; m_ctrl = CRST & CWMASK; m_fa = 0;
    m_jaddr = 0; m_es = 0;
  endtask

  function automatic logic [31:0] model_read(input logic [5:0] a);
    logic [31:0] s;
    if (a[1:0] != 2'b00) return 32'h0;
    case (a)
      6'h00: return (VAR >= 4) ? (32'(VAR) << 8) : 32'(VAR);
      6'h04: return m_full ? m_held : 32'h0;
      6'h08: return m_ctrl;
      6'h10: begin
        s = 32'(m_st) | (32'(m_full) << 3) | (32'(m_errf) << 4) | (32'(e_units) << 9)
            | (m_batch ? 32'h0001_0000 : 32'h0002_0000) | (32'(e_istate) << 24);
        return s;
      end
      6'h14: return m_es;
      6'h18: return m_fa;
      6'h1C: return m_cur;
      6'h20: return m_init;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      bit wd, wc, wk, busy, qnow;
      logic [31:0] na;
      wd = b_wr && b_addr == 6'h04;
      wc = b_wr && b_addr == 6'h0C;
      wk = b_wr && b_addr == 6'h08;
      busy = (m_st == 1);
      qnow = 0;
      m_start = 0;
      if (wc && b_wdata[0]) begin
        m_st = 0; m_full = 0; m_pend = 0; m_errf = 0; m_batch = 0;
        m_ctrl = CRST & CWMASK; m_es = 0; m_fa = 0;
      end else begin
        if (wc && b_wdata[8]) begin m_pend = 0; if (m_st == 4) m_st = 0; end
        if (wc && b_wdata[9]) begin m_errf = 0; m_es = 0; if (m_st == 2 || m_st == 3) m_st = 0; end
        if (wc && b_wdata[16]) m_batch = 1;
        if (wk) m_ctrl = b_wdata & CWMASK;
        if (wd && (m_st == 0 || m_st == 4)) begin
          m_start = 1; m_jaddr = b_wdata; m_st = 1; m_init = b_wdata; m_cur = b_wdata;
        end else if (wd && busy && !m_full) qnow = 1;
        if (busy) m_cur = e_cur;
        if (busy && e_fault) begin
          m_st = 3; m_errf = 1; m_pend = 1; m_full = 0; m_fa = e_faddr;
        end else if (busy && e_err) begin
          m_st = 2; m_errf = 1; m_pend = 1; m_full = 0; m_es = {2'b00, e_info};
        end else if (busy && e_done) begin
          m_pend = 1;
          if (m_full || qnow) begin
            na = m_full ? m_held : b_wdata;
            m_start = 1; m_jaddr = na; m_init = na; m_cur = na; m_full = 0;
          end else m_st = 4;
        end else if (qnow) begin
          m_full = 1; m_held = b_wdata;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00: return "R2 version";
      6'h04: return "R4 held address";
      6'h08: return "R11 control";
      6'h10: return "R12 status";
      6'h14: return "R6 error status";
      6'h18: return "R7 fault address";
      6'h1C: return "R13 current address";
      6'h20: return "R3 initial address";
      default: return "R14 unmapped";
    endcase
  endfunction

  // compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_live && !finished) begin
      chk(irq == (m_pend && m_ctrl[4]), "R8 irq (model)", 32'(irq), 32'(m_pend && m_ctrl[4]));
      chk(jstart == m_start, "R3 job_start (model)", 32'(jstart), 32'(m_start));
      if (m_start) chk(jaddr == m_jaddr, "R3 job_addr (model)", jaddr, m_jaddr);
      chk(rdata == model_read(b_addr), tag_of(b_addr), rdata, model_read(b_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #(PERIOD/4);
    b_wr = 1'b1; b_addr = a; b_wdata = d;
    @(posedge clk); #(PERIOD/4);
    b_wr = 1'b0;
  endtask

  task automatic eng_pulse(input bit dn, input bit er, input bit ft);
    @(posedge clk); #(PERIOD/4);
    e_done = dn; e_err = er; e_fault = ft;
    @(posedge clk); #(PERIOD/4);
    e_done = 1'b0; e_err = 1'b0; e_fault = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #(PERIOD/4);
    b_addr = a;
    @(negedge clk);
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic peek_irq(input bit exp, input string tag);
    @(negedge clk);
    chk(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #(PERIOD/4) rst_n = 1'b1;
    m_live = 1'b1;

    // R1 / R2: reset values
    peek(6'h10, 32'h0002_0000, "R1 status after reset");
    peek(6'h08, 32'h0008_0000, "R1 control after reset");
    peek_irq(1'b0, "R1 irq after reset");
    peek(6'h00, 32'h0000_0003, "R2 version value");

    // R11: write mask
    bus_write(6'h08, 32'hFFFF_FFFF);
    peek(6'h08, 32'hFFFF_0090, "R11 control mask");
    bus_write(6'h08, 32'h0000_0010);
    peek(6'h08, 32'h0000_0010, "R11 control enable only");

    // R3: launch from idle
    bus_write(6'h04, 32'h0000_1000);
    peek(6'h10, 32'h0002_0001, "R3 busy after start");
    peek(6'h20, 32'h0000_1000, "R3 initial address");
    e_cur = 32'h0000_1040;
    peek(6'h1C, 32'h0000_1040, "R13 current follows engine");

    // R4: queue, drop third write
    bus_write(6'h04, 32'h0000_2000);
    peek(6'h10, 32'h0002_0009, "R4 queue full flag");
    bus_write(6'h04, 32'h0000_3000);
    peek(6'h04, 32'h0000_2000, "R4 third write dropped");
    eng_pulse(1, 0, 0);
    peek(6'h10, 32'h0002_0001, "R4 relaunch keeps busy");
    peek_irq(1'b1, "R8 pending on relaunch");
    peek(6'h20, 32'h0000_2000, "R4 queued address launched");

    // R5: complete and clear interrupt
    bus_write(6'h0C, 32'h0000_0100);
    peek_irq(1'b0, "R8 clear interrupt");
    eng_pulse(1, 0, 0);
    peek(6'h10, 32'h0002_0004, "R5 complete state");
    peek_irq(1'b1, "R8 irq on complete");
    bus_write(6'h0C, 32'h0000_0100);
    peek(6'h10, 32'h0002_0000, "R5 clear to idle");

    // R13: stray pulse in idle
    eng_pulse(1, 1, 0);
    peek(6'h10, 32'h0002_0000, "R13 pulse ignored when idle");
    peek_irq(1'b0, "R13 no irq from stray pulse");

    // R6: error path
    bus_write(6'h04, 32'h0000_4000);
    e_info = 30'h1234_5ABE;
    eng_pulse(1, 1, 0);
    peek(6'h10, 32'h0002_0012, "R6 error state and flag");
    peek(6'h14, 32'h1234_5ABE, "R6 error code captured");
    bus_write(6'h04, 32'h0000_6000);
    peek(6'h10, 32'h0002_0012, "R13 descriptor ignored in error");
    bus_write(6'h0C, 32'h0000_0100);
    peek(6'h10, 32'h0002_0012, "R6 clear-int keeps error state");
    peek_irq(1'b0, "R6 clear-int drops irq");
    bus_write(6'h0C, 32'h0000_0200);
    peek(6'h10, 32'h0002_0000, "R6 clear-err to idle");
    peek(6'h14, 32'h0000_0000, "R6 error code cleared");

    // R7: fault path with priority
    bus_write(6'h04, 32'h0000_5000);
    e_faddr = 32'hDEAD_0000;
    eng_pulse(1, 1, 1);
    peek(6'h10, 32'h0002_0013, "R7 fault state wins");
    peek(6'h18, 32'hDEAD_0000, "R7 fault address");
    peek_irq(1'b1, "R8 irq on fault");
    bus_write(6'h0C, 32'h0000_0300);
    peek(6'h10, 32'h0002_0000, "R7 fault cleared");

    // R10 / R12: batch and live flags
    bus_write(6'h0C, 32'h0001_0000);
    peek(6'h10, 32'h0001_0000, "R10 batch mode");
    e_units = 3'b101; e_istate = 8'hA5;
    peek(6'h10, 32'hA501_0A00, "R12 unit flags and state byte");
    e_units = 3'b000; e_istate = 8'h00;

    // R9: soft reset
    bus_write(6'h04, 32'h0000_7000);
    eng_pulse(1, 0, 0);
    peek(6'h10, 32'h0001_0004, "R5 complete in batch");
    bus_write(6'h0C, 32'h0000_0001);
    peek(6'h10, 32'h0002_0000, "R9 soft reset status");
    peek(6'h08, 32'h0008_0000, "R9 control restored");
    peek_irq(1'b0, "R9 irq cleared");

    // R14: unmapped, read-only, misaligned
    peek(6'h24, 32'h0000_0000, "R14 unmapped reads zero");
    peek(6'h0C, 32'h0000_0000, "R14 command reads zero");
    bus_write(6'h10, 32'hFFFF_FFFF);
    peek(6'h10, 32'h0002_0000, "R14 status write ignored");
    bus_write(6'h09, 32'hFFFF_FFFF);
    peek(6'h08, 32'h0008_0000, "R14 misaligned write ignored");
    peek(6'h0A, 32'h0000_0000, "R14 misaligned reads zero");

    repeat (2) @(posedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule